// File: doc/BRIEF.md
# Keyboard Matrix Column Scanner

This block is the read side of a keyboard matrix of 8 columns by 7 rows. Software writes a byte into a scan-control register to choose what a read of the row port returns. The 56 raw key states come in on one flat bus. Key `k` belongs to column `k / 7` and row `k % 7`, so column `c`, row `r` sits at bit `c*7 + r`. A pressed key drives its bit high.

The control value picks one of three results:
- **Single column.** When the select bit (bit 3) is set, bits 2:0 name one column, and that column's seven row states appear on bits 6:0 of the row port.
- **Any key.** When the control value is exactly zero, each row bit is the OR of that row over all eight columns. A driver can use this to see whether any key is down before it scans column by column.
- **Nothing.** Any other value with bit 3 clear gives zero.

The row port is combinational from the control register and the key bus. It follows key changes in the same cycle, and it follows a control write one clock after the write.

Top module: `kscan_top`

## Requirements
- R1: After reset the scan-control register reads back 0x00. With that value the row port shows the all-column OR.
- R2: A cycle with `ctrlWrEn` high stores `ctrlWrData` into the scan-control register. From the next cycle on, `ctrlRdData` returns that byte. The value holds while `ctrlWrEn` is low.
- R3: When control bit 3 is 1, `rowData[6:0]` equals `keyState[c*7 +: 7]`, with `c = ctrl[2:0]`. Row `r` appears on `rowData[r]`.
- R4: When the control value is 0x00, `rowData[r]` is the OR of `keyState[c*7 + r]` over columns 0 to 7.
- R5: When the control value is nonzero and bit 3 is 0, `rowData` is 0x00 whatever keys are pressed.
- R6: `rowData[7]` is always 0.
- R7: Control bits 7:4 have no effect on the row port when bit 3 is 1. For example, 0xF9 and 0x09 both select column 1.
- R8: The row port reflects a change on `keyState` in the same cycle, with no register between the key bus and `rowData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Write strobe for the scan-control register |
| ctrlWrData | input | 8 | Byte to store in the scan-control register |
| ctrlRdData | output | 8 | Current scan-control register value |
| keyState | input | 56 | Raw key states, bit `c*7 + r`, active high |
| rowData | output | 8 | Row port read value |

## Verification
The checker tests every cycle:
- the reset value of the register;
- storing on a write and holding without one;
- the single-column, all-column and zero result modes against the current register value and key bus;
- the constant-zero top bit.

Only the directed scenarios show the following:
- the extreme key indices 0 and 55 land on the right row bits;
- the ignored upper control bits really leave the selection unchanged;
- the row port tracks key changes in the same cycle without a write.

// File: rtl/kscan_pkg.sv
package kscan_pkg;

  localparam int KS_COLS   = 8;
  localparam int KS_ROWS   = 7;
  localparam int KS_CTRL_W = 8;
  localparam int KS_COL_W  = $clog2(KS_COLS);

  // Strobes from the control decode to the row datapath
  typedef struct packed {
    logic                pickOne;   // present a single column
    logic                pickAll;   // merge all columns
    logic [KS_COL_W-1:0] column;    // column chosen when pickOne
  } scanSel_t;

endpackage

// File: rtl/kscan_ctrl.sv
module kscan_ctrl
  import kscan_pkg::*;
#(
  parameter int CTRL_W = KS_CTRL_W,
  parameter int COL_W  = KS_COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output logic [CTRL_W-1:0] ctrlRdData,
  output scanSel_t          sel
);

  // The select flag sits just above the column field
  localparam int SEL_BIT = COL_W;

  logic [CTRL_W-1:0] ctrlReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (ctrlWrEn) begin
      ctrlReg <= ctrlWrData;
    end
  end

  assign ctrlRdData = ctrlReg;

  always_comb begin
    sel         = '0;
    sel.pickOne = ctrlReg[SEL_BIT];
    sel.pickAll = (ctrlReg == '0);
    sel.column  = ctrlReg[COL_W-1:0];
  end

endmodule

// File: rtl/kscan_datapath.sv
module kscan_datapath
  import kscan_pkg::*;
#(
  parameter int NUM_COLS = KS_COLS,
  parameter int NUM_ROWS = KS_ROWS,
  parameter int OUT_W    = KS_CTRL_W
) (
  input  scanSel_t                       sel,
  input  logic [NUM_COLS*NUM_ROWS-1:0]   keyState,
  output logic [OUT_W-1:0]               rowData
);

  logic [NUM_ROWS-1:0] colRows [NUM_COLS];
  logic [NUM_ROWS-1:0] anyRows;
  logic [NUM_ROWS-1:0] oneCol;
  logic [NUM_ROWS-1:0] rowsOut;

  // Column-major view of the flat key bus
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign colRows[c] = keyState[c*NUM_ROWS +: NUM_ROWS];
  end

  // Per-row reduction across every column
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic [NUM_COLS-1:0] rowSlice;
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_bit
      assign rowSlice[c] = keyState[c*NUM_ROWS + r];
    end
    assign anyRows[r] = |rowSlice;
  end

  assign oneCol = colRows[sel.column];

  always_comb begin
    rowsOut = '0;
    if (sel.pickOne) begin
      rowsOut = oneCol;
    end else if (sel.pickAll) begin
      rowsOut = anyRows;
    end
  end

  assign rowData = OUT_W'(rowsOut);

endmodule

// File: rtl/kscan_top.sv
module kscan_top
  import kscan_pkg::*;
#(
  parameter int NUM_COLS = KS_COLS,
  parameter int NUM_ROWS = KS_ROWS,
  parameter int CTRL_W   = KS_CTRL_W,
  localparam int KEYS    = NUM_COLS * NUM_ROWS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output logic [CTRL_W-1:0] ctrlRdData,
  input  logic [KEYS-1:0]   keyState,
  output logic [CTRL_W-1:0] rowData
);

  scanSel_t sel;

  kscan_ctrl #(
    .CTRL_W (CTRL_W),
    .COL_W  (KS_COL_W)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .ctrlRdData (ctrlRdData),
    .sel        (sel)
  );

  kscan_datapath #(
    .NUM_COLS (NUM_COLS),
    .NUM_ROWS (NUM_ROWS),
    .OUT_W    (CTRL_W)
  ) i_datapath (
    .sel      (sel),
    .keyState (keyState),
    .rowData  (rowData)
  );

endmodule

// File: rtl/kscan_checker.sv
module kscan_checker #(
  parameter int NUM_COLS = 8,
  parameter int NUM_ROWS = 7,
  parameter int CTRL_W   = 8,
  localparam int KEYS    = NUM_COLS * NUM_ROWS,
  localparam int COL_W   = $clog2(NUM_COLS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWrEn,
  input logic [CTRL_W-1:0] ctrlWrData,
  input logic [CTRL_W-1:0] ctrlRdData,
  input logic [KEYS-1:0]   keyState,
  input logic [CTRL_W-1:0] rowData
);

  logic [NUM_ROWS-1:0] refAny;
  logic [NUM_ROWS-1:0] refOne;

  always_comb begin
    refAny = '0;
    for (int c = 0; c < NUM_COLS; c++) begin
      refAny = refAny | keyState[c*NUM_ROWS +: NUM_ROWS];
    end
    refOne = keyState[int'(ctrlRdData[COL_W-1:0])*NUM_ROWS +: NUM_ROWS];
  end

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> ctrlRdData == '0);

  assert_write_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn |=> ctrlRdData == $past(ctrlWrData));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrEn |=> $stable(ctrlRdData));

  assert_single_col_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[COL_W] |-> rowData[NUM_ROWS-1:0] == refOne);

  assert_merge_all_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData == '0 |-> rowData[NUM_ROWS-1:0] == refAny);

  assert_blank_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdData != '0 && !ctrlRdData[COL_W]) |-> rowData == '0);

  assert_top_bit_R6: assert property (@(posedge clk) disable iff (!rstN)
    rowData[CTRL_W-1] == 1'b0);

endmodule

bind kscan_top kscan_checker #(
  .NUM_COLS (NUM_COLS),
  .NUM_ROWS (NUM_ROWS),
  .CTRL_W   (CTRL_W)
) i_kscan_checker (
  .clk        (clk),
  .rstN       (rstN),
  .ctrlWrEn   (ctrlWrEn),
  .ctrlWrData (ctrlWrData),
  .ctrlRdData (ctrlRdData),
  .keyState   (keyState),
  .rowData    (rowData)
);

// File: tb/test_kscan_top.sv
`timescale 1ns/1ps
module test_kscan_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [7:0]  ctrlWrData = '0;
  logic [55:0] keyState = '0;
  logic [7:0]  ctrlRdData;
  logic [7:0]  rowData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  kscan_top i_kscan_top (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .ctrlRdData (ctrlRdData),
    .keyState   (keyState),
    .rowData    (rowData)
  );

  // Expected row byte from the requirements (R3, R4, R5, R6)
  function automatic logic [7:0] expRow(input logic [7:0] ctl, input logic [55:0] keys);
    logic [7:0] res = 8'h00;
    if (ctl[3]) begin
      for (int r = 0; r < 7; r++) res[r] = keys[int'(ctl[2:0])*7 + r];
    end else if (ctl == 8'h00) begin
      for (int c = 0; c < 8; c++)
        for (int r = 0; r < 7; r++) res[r] = res[r] | keys[c*7 + r];
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [7:0] v);
    @(negedge clk);
    ctrlWrEn   = 1'b1;
    ctrlWrData = v;
    @(negedge clk);
    ctrlWrEn   = 1'b0;
    ctrlWrData = 8'h00;
  endtask

  task automatic testReset();
    keyState = 56'h0;
    keyState[0 * 7 + 2] = 1'b1;
    keyState[5 * 7 + 4] = 1'b1;
    #1;
    check("R1 ctrl after reset", ctrlRdData, 8'h00);
    check("R1 row port after reset", rowData, 8'h14);
  endtask

  task automatic testWriteReadback();
    writeCtrl(8'hA5);
    check("R2 readback A5", ctrlRdData, 8'hA5);
    repeat (3) @(negedge clk);
    check("R2 hold without write", ctrlRdData, 8'hA5);
    writeCtrl(8'h3C);
    check("R2 readback 3C", ctrlRdData, 8'h3C);
  endtask

  task automatic testSingleColumn();
    for (int c = 0; c < 8; c++) begin
      keyState = 56'h0;
      keyState[c*7 +: 7] = 7'(8'h11 * (c + 1));
      writeCtrl(8'(8 + c));
      check($sformatf("R3 column %0d", c), rowData, expRow(8'(8 + c), keyState));
    end
    keyState = 56'h0;
    keyState[0] = 1'b1;
    writeCtrl(8'h08);
    check("R3 key index 0", rowData, 8'h01);
    writeCtrl(8'h09);
    check("R3 key 0 absent from column 1", rowData, 8'h00);
    keyState = 56'h0;
    keyState[55] = 1'b1;
    writeCtrl(8'h0F);
    check("R3 key index 55", rowData, 8'h40);
  endtask

  task automatic testMergeAll();
    keyState = 56'h0;
    writeCtrl(8'h00);
    check("R4 no keys", rowData, 8'h00);
    keyState[1*7 + 0] = 1'b1;
    keyState[3*7 + 3] = 1'b1;
    keyState[7*7 + 6] = 1'b1;
    keyState[6*7 + 3] = 1'b1;
    #1;
    check("R4 merged rows", rowData, 8'h49);
  endtask

  task automatic testOtherValues();
    logic [7:0] vals [6] = '{8'h01, 8'h07, 8'h10, 8'h80, 8'hF0, 8'h77};
    keyState = '1;
    foreach (vals[i]) begin
      writeCtrl(vals[i]);
      check($sformatf("R5 blank for %h", vals[i]), rowData, 8'h00);
    end
  endtask

  task automatic testUpperBits();
    logic [7:0] ref9;
    keyState = 56'h0;
    keyState[1*7 +: 7] = 7'h2B;
    keyState[0 +: 7]   = 7'h7F;
    writeCtrl(8'h09);
    ref9 = rowData;
    check("R7 base select 09", ref9, 8'h2B);
    writeCtrl(8'hF9);
    check("R7 select F9 same as 09", rowData, ref9);
    writeCtrl(8'h59);
    check("R7 select 59 same as 09", rowData, ref9);
  endtask

  task automatic testTopBit();
    keyState = '1;
    writeCtrl(8'h00);
    check("R6 bit7 merge mode", {rowData[7], 7'h0}, 8'h00);
    writeCtrl(8'hFC);
    check("R6 bit7 single mode", {rowData[7], 7'h0}, 8'h00);
    check("R6 full byte single mode", rowData, 8'h7F);
  endtask

  task automatic testLiveKeys();
    writeCtrl(8'h0B);
    keyState = 56'h0;
    #1;
    check("R8 column 3 idle", rowData, 8'h00);
    @(negedge clk);
    keyState[3*7 + 5] = 1'b1;
    #1;
    check("R8 same-cycle key press", rowData, 8'h20);
    keyState[3*7 + 5] = 1'b0;
    #1;
    check("R8 same-cycle key release", rowData, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWriteReadback();
    testSingleColumn();
    testMergeAll();
    testOtherValues();
    testUpperBits();
    testTopBit();
    testLiveKeys();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule